// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel data buses, called A and B. Data can flow across it in either direction, and each direction has its own storage register. The A-side register samples the A bus on the rising edge of the A-to-B clock. The B-side register samples the B bus on the rising edge of the B-to-A clock. Sampling is never gated, so every rising edge on a register clock stores whatever value is present on that register's bus at that moment.

An active-low output enable and a direction input decide which bus, if either, is driven. With the enable high both buses are isolated, and the block only captures and holds. With the enable low, the direction input picks the driven side. A low direction drives A from B; a high direction drives B from A.

For each direction, a select input picks what goes onto the driven bus: either the live value from the opposite bus, or the stored register value. Each bus is modelled as a separate input port, output port and drive-enable port, so a pad or tri-state wrapper can be added at a higher level.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When `rst` is high on a rising edge of a register's clock, that register clears to zero. This is observed through the stored-data path of the bus that register feeds.
- R2: On every rising edge of `clk_a2b`, the A register stores the value present on bus A, whatever the state of `out_en_n` and `dir_to_b`.
- R3: On every rising edge of `clk_b2a`, the B register stores the value present on bus B, whatever the state of `out_en_n` and `dir_to_b`.
- R4: With `out_en_n` = 1, the following hold:
  - `a_oe` and `b_oe` are both 0.
  - `a_out` and `b_out` are both 0.
  - A register that receives no clock edge keeps its contents.
- R5: With `out_en_n` = 0, the drive enables follow `dir_to_b` in the same cycle:
  - `dir_to_b` = 0 gives `a_oe` = 1 and `b_oe` = 0.
  - `dir_to_b` = 1 gives `b_oe` = 1 and `a_oe` = 0.
- R6: While `a_oe` = 1, the value of `a_out` depends on `use_stored_b2a`:
  - `use_stored_b2a` = 0 makes `a_out` equal `b_in`, combinationally.
  - `use_stored_b2a` = 1 makes `a_out` equal the B register.
- R7: While `b_oe` = 1, the value of `b_out` depends on `use_stored_a2b`:
  - `use_stored_a2b` = 0 makes `b_out` equal `a_in`, combinationally.
  - `use_stored_a2b` = 1 makes `b_out` equal the A register.
- R8: `a_oe` and `b_oe` are never 1 at the same time.
- R9: When both register clocks rise on the same edge while the buses are isolated, both registers load their own bus values.
- R10: A register clocked while its own bus is the driven side stores the value the block is driving onto that bus, which is `a_out` or `b_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Synchronous active-high clear of both registers, taken on each register's own clock |
| clk_a2b | input | 1 | Capture clock of the A register, rising edge |
| clk_b2a | input | 1 | Capture clock of the B register, rising edge |
| out_en_n | input | 1 | Active-low output enable; high isolates both buses |
| dir_to_b | input | 1 | 0 drives bus A, 1 drives bus B (when enabled) |
| use_stored_a2b | input | 1 | 1 drives the A register onto bus B, 0 passes `a_in` live |
| use_stored_b2a | input | 1 | 1 drives the B register onto bus A, 0 passes `b_in` live |
| a_in | input | W | Value received from bus A |
| a_out | output | W | Value driven onto bus A (0 when not driven) |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | W | Value received from bus B |
| b_out | output | W | Value driven onto bus B (0 when not driven) |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
The hardest case to reach from the ports is a register clocked while its own bus is the driven side. In that case the stored value must come from the opposite bus through the live path, not from the stale input pin. To reach it, the bench enables bus B with the live select, places a marker on `a_in` that differs from `b_in`, and pulses `clk_b2a`. It then turns the direction around and selects stored data, so the B register appears on `a_out`. Register contents are always read back this way, through the stored-data path in the direction that reveals them, so the registers are never inspected directly.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Which bus the block is currently driving.
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  function automatic drive_e decode_drive(input logic en_n, input logic to_b);
    if (en_n) return DRV_NONE;
    return to_b ? DRV_B : DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic   out_en_n,
  input  logic   dir_to_b,
  output drive_e mode
);

  // Purely combinational so the enables track the controls in the same cycle.
  always_comb begin
    mode = decode_drive(out_en_n, dir_to_b);
  end

endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] CLEAR_VAL = '0;

  // Loads on every rising edge; no enable by design.
  always_ff @(posedge clk) begin
    if (rst) q <= CLEAR_VAL;
    else     q <= d;
  end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] dout
);

  localparam logic [W-1:0] IDLE_VAL = '0;

  always_comb begin
    if (!en)             dout = IDLE_VAL;
    else if (use_stored) dout = stored;
    else                 dout = live;
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rst,
  input  logic         clk_a2b,
  input  logic         clk_b2a,
  input  logic         out_en_n,
  input  logic         dir_to_b,
  input  logic         use_stored_a2b,
  input  logic         use_stored_b2a,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);

  drive_e         mode;
  logic [W-1:0]   a_store_q;
  logic [W-1:0]   b_store_q;
  logic [W-1:0]   a_bus_val;
  logic [W-1:0]   b_bus_val;

  xcvr_drive_ctrl u_ctrl (
    .out_en_n (out_en_n),
    .dir_to_b (dir_to_b),
    .mode     (mode)
  );

  assign a_oe = (mode == DRV_A);
  assign b_oe = (mode == DRV_B);

  // The value actually on each bus: our own drive when enabled, else the pin.
  assign a_bus_val = a_oe ? a_out : a_in;
  assign b_bus_val = b_oe ? b_out : b_in;

  xcvr_store_reg #(.W(W)) u_a_reg (
    .clk (clk_a2b),
    .rst (rst),
    .d   (a_bus_val),
    .q   (a_store_q)
  );

  xcvr_store_reg #(.W(W)) u_b_reg (
    .clk (clk_b2a),
    .rst (rst),
    .d   (b_bus_val),
    .q   (b_store_q)
  );

  // Drives bus B from A (live pin or A register).
  xcvr_path_mux #(.W(W)) u_to_b (
    .en         (b_oe),
    .use_stored (use_stored_a2b),
    .live       (a_in),
    .stored     (a_store_q),
    .dout       (b_out)
  );

  // Drives bus A from B (live pin or B register).
  xcvr_path_mux #(.W(W)) u_to_a (
    .en         (a_oe),
    .use_stored (use_stored_b2a),
    .live       (b_in),
    .stored     (b_store_q),
    .dout       (a_out)
  );

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int W = 8
) (
  input logic         rst,
  input logic         clk_a2b,
  input logic         clk_b2a,
  input logic         out_en_n,
  input logic         use_stored_a2b,
  input logic         use_stored_b2a,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q
);

  logic [W-1:0] a_seen;
  logic [W-1:0] b_seen;
  assign a_seen = a_oe ? a_out : a_in;
  assign b_seen = b_oe ? b_out : b_in;

  always_comb begin
    if (!$isunknown({a_oe, b_oe})) begin
      AST_ONE_BUS_DRIVEN: assert (!(a_oe && b_oe)); // R8
    end
    if (!$isunknown({out_en_n, a_oe, b_oe})) begin
      AST_ISOLATED_NO_DRIVE: assert (!out_en_n || (!a_oe && !b_oe)); // R4
    end
    if (!$isunknown({a_oe, use_stored_b2a, b_in, a_out})) begin
      AST_A_LIVE_PATH: assert (!(a_oe && !use_stored_b2a) || a_out == b_in); // R6
    end
    if (!$isunknown({b_oe, use_stored_a2b, a_in, b_out})) begin
      AST_B_LIVE_PATH: assert (!(b_oe && !use_stored_a2b) || b_out == a_in); // R7
    end
  end

  AST_A_CAPTURE: assert property (@(posedge clk_a2b) disable iff (rst)
    !rst |=> a_q == $past(a_seen)); // R2

  AST_B_CAPTURE: assert property (@(posedge clk_b2a) disable iff (rst)
    !rst |=> b_q == $past(b_seen)); // R3

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.W(W)) u_chk (
  .rst            (rst),
  .clk_a2b        (clk_a2b),
  .clk_b2a        (clk_b2a),
  .out_en_n       (out_en_n),
  .use_stored_a2b (use_stored_a2b),
  .use_stored_b2a (use_stored_b2a),
  .a_in           (a_in),
  .a_out          (a_out),
  .a_oe           (a_oe),
  .b_in           (b_in),
  .b_out          (b_out),
  .b_oe           (b_oe),
  .a_q            (a_store_q),
  .b_q            (b_store_q)
);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, clk_a2b, clk_b2a, out_en_n, dir_to_b;
  logic         use_stored_a2b, use_stored_b2a;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  bus_xcvr_reg #(.W(W)) dut (
    .rst(rst), .clk_a2b(clk_a2b), .clk_b2a(clk_b2a),
    .out_en_n(out_en_n), .dir_to_b(dir_to_b),
    .use_stored_a2b(use_stored_a2b), .use_stored_b2a(use_stored_b2a),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit pa, input bit pb);
    @(negedge clk);
    clk_a2b = pa;
    clk_b2a = pb;
    @(negedge clk);
    clk_a2b = 1'b0;
    clk_b2a = 1'b0;
    #1;
  endtask

  // Read the A register through the stored path onto bus B.
  task automatic peek_a(output logic [W-1:0] v);
    out_en_n = 1'b0; dir_to_b = 1'b1; use_stored_a2b = 1'b1;
    #1 v = b_out;
  endtask

  // Read the B register through the stored path onto bus A.
  task automatic peek_b(output logic [W-1:0] v);
    out_en_n = 1'b0; dir_to_b = 1'b0; use_stored_b2a = 1'b1;
    #1 v = a_out;
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    out_en_n = 1'b1; a_in = 8'h55; b_in = 8'hAA;
    rst = 1'b1;
    pulse(1, 1);
    rst = 1'b0;
    peek_a(v); check("R1 A register cleared", v, 8'h00);
    peek_b(v); check("R1 B register cleared", v, 8'h00);
  endtask

  task automatic t_isolation();
    logic [W-1:0] v;
    for (int d = 0; d < 2; d++) begin
      out_en_n = 1'b1; dir_to_b = d[0];
      #1;
      check("R4 a_oe off", {7'd0, a_oe}, 8'h00);
      check("R4 b_oe off", {7'd0, b_oe}, 8'h00);
      check("R4 a_out idle", a_out, 8'h00);
      check("R4 b_out idle", b_out, 8'h00);
    end
    a_in = 8'h3C; b_in = 8'hC3;
    pulse(1, 1);
    peek_a(v); check("R9 A loaded on joint edge", v, 8'h3C);
    peek_b(v); check("R9 B loaded on joint edge", v, 8'hC3);
    out_en_n = 1'b1; a_in = 8'hE1; b_in = 8'h1E;
    #1;
    peek_a(v); check("R4 A register holds", v, 8'h3C);
    peek_b(v); check("R4 B register holds", v, 8'hC3);
  endtask

  task automatic t_enables();
    out_en_n = 1'b0; dir_to_b = 1'b0; #1;
    check("R5 dir0 a_oe", {7'd0, a_oe}, 8'h01);
    check("R8 dir0 b_oe", {7'd0, b_oe}, 8'h00);
    dir_to_b = 1'b1; #1;
    check("R5 dir1 b_oe", {7'd0, b_oe}, 8'h01);
    check("R8 dir1 a_oe", {7'd0, a_oe}, 8'h00);
  endtask

  task automatic t_mux();
    out_en_n = 1'b0; dir_to_b = 1'b0; use_stored_b2a = 1'b0;
    b_in = 8'h77; #1;
    check("R6 live B to A", a_out, 8'h77);
    b_in = 8'h78; #1;
    check("R6 live B follows", a_out, 8'h78);
    use_stored_b2a = 1'b1; #1;
    check("R6 stored B to A", a_out, 8'hC3);
    dir_to_b = 1'b1; use_stored_a2b = 1'b0; a_in = 8'h19; #1;
    check("R7 live A to B", b_out, 8'h19);
    check("R7 A bus not driven", a_out, 8'h00);
    use_stored_a2b = 1'b1; #1;
    check("R7 stored A to B", b_out, 8'h3C);
  endtask

  task automatic t_capture();
    logic [W-1:0] v;
    // B driven, A is an input: A captures under enable (R2).
    out_en_n = 1'b0; dir_to_b = 1'b1; use_stored_a2b = 1'b0;
    a_in = 8'h11; b_in = 8'hF0;
    pulse(1, 0);
    peek_a(v); check("R2 A captures while enabled", v, 8'h11);
    // B driven live from a_in: B register must take the driven value (R10).
    dir_to_b = 1'b1; use_stored_a2b = 1'b0; a_in = 8'h4D; b_in = 8'hF0;
    pulse(0, 1);
    peek_b(v); check("R10 B captures driven value", v, 8'h4D);
    // A driven, B is an input: B captures its pin (R3).
    dir_to_b = 1'b0; use_stored_b2a = 1'b0; b_in = 8'h5A; a_in = 8'h0F;
    pulse(0, 1);
    peek_b(v); check("R3 B captures pin", v, 8'h5A);
    // A driven from stored B: A register takes the driven value (R10).
    dir_to_b = 1'b0; use_stored_b2a = 1'b1; a_in = 8'h00;
    pulse(1, 0);
    peek_a(v); check("R10 A captures driven value", v, 8'h5A);
  endtask

  initial begin
    rst = 1'b0; clk_a2b = 1'b0; clk_b2a = 1'b0;
    out_en_n = 1'b1; dir_to_b = 1'b0;
    use_stored_a2b = 1'b0; use_stored_b2a = 1'b0;
    a_in = '0; b_in = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_isolation();
    t_enables();
    t_mux();
    t_capture();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule